// File: doc/BRIEF.md
# Programmable Video Line Buffer Chain

This block holds seven programmable line delays in series. It delivers eight vertically aligned taps to a downstream vertical filter: the newest registered sample and the seven buffer outputs, ordered from the smallest delay to the largest. Each delay can be set from 4 to 3076 samples. The block supports four further functions. A recirculate mode replays stored lines. A parallel preload fills every buffer from the single input. A second-field input can replace the source of the last stage for odd/even field filtering. A trim option shortens the first stage by two samples when the chain is fed by an upstream chain's cascade output.

Samples move on a valid/ready stream. A sample is accepted on a rising edge where `in_valid` and `in_ready` are both high. Each accepted sample advances every buffer by one position and presents one new tap set with `out_valid` high. The tap set must then be taken: while `out_valid` is high and `out_ready` is low, `in_ready` is low and every output holds. `in_ready` equals `out_ready OR NOT out_valid`, so a new sample can be accepted in the same cycle the previous tap set is taken. The configuration pins are plain levels. They are meant to change only in reset or while no samples are flowing. A new length value is picked up by each buffer at its next pointer wrap, and by all buffers at reset.

Top module: `vline_chain`

## Requirements
- R1: With L = cfg_len + 4, tap 0 after the n-th accepted sample equals input sample n, and tap k (k = 1..7) equals input sample n − k·L, in delay mode with no options set.
- R2: A cfg_len value above 3072 behaves exactly as 3072, giving L = 3076.
- R3: After reset, out_valid is 0, in_ready is 1 and out_cascade is 0.
- R4: With cfg_recirc = 1 and cfg_pload = 0, each buffer k is fed back from its own output. From the switch onward, tap k repeats the sequence it held, with a period equal to that buffer's length. Tap 0 keeps following the input.
- R5: With cfg_pload = 1, every buffer is fed from the input register, so tap k equals input sample n − Lk, where Lk is that buffer's own length. Preload takes priority over cfg_recirc.
- R6: With cfg_cascade = 1, the first buffer's length is L − 2 and all other buffers keep length L. Each tap k ≥ 1 therefore arrives two samples earlier than in R1.
- R7: With cfg_field = 1 and cfg_field_buf = 0, tap 7 equals the alternate input accepted with the same sample. With cfg_field = 0, cfg_field_buf has no effect.
- R8: With cfg_field = 1 and cfg_field_buf = 1, the last buffer takes the alternate input, whether or not preload is set. Tap 7 then equals alternate sample n − L.
- R9: out_cascade after accepted sample n equals the value tap 7 had after sample n − 1.
- R10: While out_valid = 1 and out_ready = 0, in_ready is 0 and all taps and out_cascade hold. With no sample accepted and out_ready = 1, out_valid drops to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Chain can accept a sample |
| in_data | input | 12 | Main two's complement sample |
| in_alt | input | 12 | Alternate field sample, accepted with in_data |
| out_valid | output | 1 | Tap set present |
| out_ready | input | 1 | Consumer takes the tap set |
| out_taps | output | 8x12 | Taps, index 0 newest to 7 oldest |
| out_cascade | output | 12 | Registered copy of tap 7, for the next chain's in_data |
| cfg_len | input | 12 | Length code, delay = value + 4 |
| cfg_recirc | input | 1 | 1 = recirculate mode |
| cfg_pload | input | 1 | 1 = load all buffers from the input |
| cfg_field | input | 1 | 1 = alternate field input feeds the last stage |
| cfg_field_buf | input | 1 | 1 = delay the alternate path by one line |
| cfg_cascade | input | 1 | 1 = first buffer shortened by two |

## Verification
Tap 0 and out_valid follow an accepted sample on the same rising edge. Tap k is due once the summed lengths of buffers 1..k (or its own length under preload) have been accepted. out_cascade lags tap 7 by exactly one accepted sample. The bench drives each sample on a falling edge and reads all outputs on the next falling edge, just after the accepting edge. It computes each expected tap as an input sample from a delay in accepted samples rather than in clock cycles, so idle and stalled cycles shift nothing. It compares a tap only once its source sample exists.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  // delay = length code + LEN_OFFSET
  localparam int unsigned LEN_OFFSET = 4;
  // cycles removed from the first stage when fed by another chain
  localparam int unsigned TRIM = 2;

  typedef enum logic [1:0] {
    SRC_CHAIN = 2'd0,
    SRC_INPUT = 2'd1,
    SRC_SELF  = 2'd2
  } wsrc_e;
endpackage

// File: rtl/vlc_ctrl.sv
module vlc_ctrl
  import vlc_pkg::*;
#(
  parameter int CW      = 12,
  parameter int LW      = 12,
  parameter int NBUF    = 7,
  parameter int MAX_CFG = 3072
) (
  input  logic [CW-1:0]            cfg_len,
  input  logic                     cfg_recirc,
  input  logic                     cfg_pload,
  input  logic                     cfg_cascade,
  output logic [NBUF-1:0][LW-1:0]  ring_len,
  output wsrc_e                    wsrc
);
  logic [CW-1:0] len_cl;
  logic [LW-1:0] base;

  // out-of-range codes saturate to the longest legal line
  assign len_cl = (cfg_len > CW'(MAX_CFG)) ? CW'(MAX_CFG) : cfg_len;
  // ring holds one less than the delay: the output register adds one
  assign base   = LW'(len_cl) + LW'(LEN_OFFSET - 1);

  generate
    for (genvar i = 0; i < NBUF; i++) begin : g_len
      if (i == 0) begin : g_first
        assign ring_len[i] = cfg_cascade ? (base - LW'(TRIM)) : base;
      end else begin : g_rest
        assign ring_len[i] = base;
      end
    end
  endgenerate

  // preload wins over recirculation
  always_comb begin
    if (cfg_pload)       wsrc = SRC_INPUT;
    else if (cfg_recirc) wsrc = SRC_SELF;
    else                 wsrc = SRC_CHAIN;
  end
endmodule

// File: rtl/vlc_ring.sv
module vlc_ring
  import vlc_pkg::*;
#(
  parameter int DW    = 12,
  parameter int DEPTH = 3075,
  parameter int LW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [LW-1:0] ring_len,
  input  wsrc_e         wsrc,
  input  logic [DW-1:0] chain_in,
  input  logic [DW-1:0] load_in,
  output logic [DW-1:0] rd_q
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ptr;
  logic [LW-1:0] len_act;
  logic [DW-1:0] wdata;
  logic [LW:0]   nxt;

  always_comb begin
    case (wsrc)
      SRC_INPUT: wdata = load_in;
      SRC_SELF:  wdata = rd_q;
      default:   wdata = chain_in;
    endcase
  end

  assign nxt = {1'b0, LW'(ptr)} + (LW+1)'(1);

  // read-first storage: the old word leaves as the new one lands
  always_ff @(posedge clk) begin
    if (adv) mem[ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      len_act <= ring_len;
      rd_q    <= '0;
    end else if (adv) begin
      rd_q <= mem[ptr];
      if (nxt >= {1'b0, len_act}) begin
        ptr     <= '0;
        len_act <= ring_len;   // new length adopted at wrap
      end else begin
        ptr <= ptr + AW'(1);
      end
    end
  end

  // R1: the pointer never leaves the active ring
  a_r1_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    LW'(ptr) < len_act);
  // R6: even a trimmed shortest ring keeps at least one word and fits storage
  a_r6_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (len_act != '0) && (len_act <= LW'(DEPTH)));
endmodule

// File: rtl/vline_chain.sv
module vline_chain
  import vlc_pkg::*;
#(
  parameter int DW      = 12,
  parameter int NBUF    = 7,
  parameter int CW      = 12,
  parameter int MAX_CFG = 3072
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [DW-1:0]               in_data,
  input  logic [DW-1:0]               in_alt,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [NBUF:0][DW-1:0]       out_taps,
  output logic [DW-1:0]               out_cascade,
  input  logic [CW-1:0]               cfg_len,
  input  logic                        cfg_recirc,
  input  logic                        cfg_pload,
  input  logic                        cfg_field,
  input  logic                        cfg_field_buf,
  input  logic                        cfg_cascade
);
  localparam int DEPTH = MAX_CFG + int'(LEN_OFFSET) - 1;
  localparam int LW    = $clog2(DEPTH + 1);

  logic                       adv;
  logic [DW-1:0]              din_q;
  logic [DW-1:0]              alt_q;
  logic [DW-1:0]              cas_q;
  logic                       vld_q;
  logic [NBUF-1:0][LW-1:0]    ring_len;
  wsrc_e                      wsrc;
  logic [NBUF-1:0][DW-1:0]    rq;

  assign in_ready = out_ready | ~vld_q;
  assign adv      = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      din_q <= '0;
      alt_q <= '0;
      cas_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (adv) begin
        din_q <= in_data;
        alt_q <= in_alt;
        cas_q <= out_taps[NBUF];
        vld_q <= 1'b1;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  vlc_ctrl #(
    .CW(CW), .LW(LW), .NBUF(NBUF), .MAX_CFG(MAX_CFG)
  ) u_ctrl (
    .cfg_len     (cfg_len),
    .cfg_recirc  (cfg_recirc),
    .cfg_pload   (cfg_pload),
    .cfg_cascade (cfg_cascade),
    .ring_len    (ring_len),
    .wsrc        (wsrc)
  );

  generate
    for (genvar i = 0; i < NBUF; i++) begin : g_buf
      logic [DW-1:0] c_in;
      logic [DW-1:0] l_in;
      if (i == NBUF - 1) begin : g_last
        // the last stage can serve the second field instead of the chain
        assign c_in = cfg_field ? alt_q : rq[i-1];
        assign l_in = cfg_field ? alt_q : din_q;
      end else if (i == 0) begin : g_head
        assign c_in = din_q;
        assign l_in = din_q;
      end else begin : g_mid
        assign c_in = rq[i-1];
        assign l_in = din_q;
      end
      vlc_ring #(
        .DW(DW), .DEPTH(DEPTH), .LW(LW)
      ) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .ring_len (ring_len[i]),
        .wsrc     (wsrc),
        .chain_in (c_in),
        .load_in  (l_in),
        .rd_q     (rq[i])
      );
    end
  endgenerate

  always_comb begin
    out_taps[0] = din_q;
    for (int k = 1; k < NBUF; k++) out_taps[k] = rq[k-1];
    out_taps[NBUF] = (cfg_field && !cfg_field_buf) ? alt_q : rq[NBUF-1];
  end

  assign out_valid   = vld_q;
  assign out_cascade = cas_q;

  // R10: a refused tap set and the cascade word stay put
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_taps) && $stable(out_cascade)));
  // R10: an empty output stage always accepts
  a_r10_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  // R3: a tap set appears only after an offered sample
  a_r3_valid_from_input: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid));
  // R9: the cascade word is tap 7 one accepted sample later
  a_r9_cascade_lag: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (out_cascade == $past(out_taps[NBUF])));
endmodule

// File: tb/vline_chain_tb.sv
`timescale 1ns/1ps
module vline_chain_tb;
  localparam int DW   = 12;
  localparam int NBUF = 7;
  localparam int HMAX = 32768;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                  rst_n;
  logic                  in_valid;
  logic                  in_ready;
  logic [DW-1:0]         in_data;
  logic [DW-1:0]         in_alt;
  logic                  out_valid;
  logic                  out_ready;
  logic [NBUF:0][DW-1:0] out_taps;
  logic [DW-1:0]         out_cascade;
  logic [11:0]           cfg_len;
  logic                  cfg_recirc, cfg_pload, cfg_field, cfg_field_buf, cfg_cascade;

  vline_chain u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_alt(in_alt),
    .out_valid(out_valid), .out_ready(out_ready), .out_taps(out_taps), .out_cascade(out_cascade),
    .cfg_len(cfg_len), .cfg_recirc(cfg_recirc), .cfg_pload(cfg_pload),
    .cfg_field(cfg_field), .cfg_field_buf(cfg_field_buf), .cfg_cascade(cfg_cascade)
  );

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] xh [HMAX];
  logic [DW-1:0] ah [HMAX];
  int L, casc, pld, fld, fbuf, rcm, n;
  string tag;

  function automatic logic [DW-1:0] xv(int i, int s);
    return DW'(((i * 1237) + (s * 311) + ((i >> 4) * 53)) ^ (i >> 2));
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int dlen(int k);
    return (k == 1 && casc != 0) ? L - 2 : L;
  endfunction

  function automatic int dsum(int k);
    int s = 0;
    if (pld != 0) return dlen(k);
    for (int j = 1; j <= k; j++) s += dlen(j);
    return s;
  endfunction

  // expected value of tap k after accepted sample i, derived from R1/R4-R8
  function automatic bit expv(int k, int i, output logic [DW-1:0] v);
    int m = i;
    int d;
    v = '0;
    if (k == NBUF && fld != 0) begin
      if (fbuf == 0) begin v = ah[i]; return 1'b1; end
      if (i - L < 0) return 1'b0;
      v = ah[i - L];
      return 1'b1;
    end
    if (rcm >= 0 && k >= 1 && m >= rcm + dlen(k) - 1)
      m = m - dlen(k) * ((m - (rcm + dlen(k) - 1)) / dlen(k) + 1);
    d = (k == 0) ? 0 : dsum(k);
    if (m - d < 0) return 1'b0;
    v = xh[m - d];
    return 1'b1;
  endfunction

  function automatic string ktag(int k);
    if (k == NBUF && fld != 0) return (fbuf != 0) ? "R8" : "R7";
    if (k == 1 && casc != 0) return "R6";
    return tag;
  endfunction

  task automatic verify(int i);
    logic [DW-1:0] v;
    checks++;
    if (out_valid !== 1'b1) begin
      fails++;
      $display("FAIL R10 out_valid actual=%0b expected=1", out_valid);
    end
    for (int k = 0; k <= NBUF; k++)
      if (expv(k, i, v)) chk(ktag(k), out_taps[k], v);
    if (i >= 1 && expv(NBUF, i - 1, v)) chk("R9", out_cascade, v);
  endtask

  task automatic do_reset(int len, int rc, int pl, int fl, int fb, int cs, int seed, string t);
    cfg_len = 12'(len); cfg_recirc = rc[0]; cfg_pload = pl[0];
    cfg_field = fl[0]; cfg_field_buf = fb[0]; cfg_cascade = cs[0];
    L = ((len > 3072) ? 3072 : len) + 4;
    casc = cs; pld = pl; fld = fl; fbuf = fb; rcm = -1; n = 0; tag = t;
    for (int i = 0; i < HMAX; i++) begin xh[i] = xv(i, seed); ah[i] = xv(i, seed + 77); end
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R3", 12'(out_valid), 12'd0);
    chk("R3", 12'(in_ready), 12'd1);
    chk("R3", out_cascade, 12'd0);
  endtask

  task automatic beat();
    in_valid = 1'b1; in_data = xh[n]; in_alt = ah[n];
    @(negedge clk);
    in_valid = 1'b0;
    verify(n);
    n++;
  endtask

  task automatic gap();
    logic [NBUF:0][DW-1:0] held;
    held = out_taps;
    @(negedge clk);
    chk("R10", 12'(out_valid), 12'd0);
    for (int k = 0; k <= NBUF; k++) chk("R10", out_taps[k], held[k]);
  endtask

  task automatic stall();
    logic [NBUF:0][DW-1:0] held;
    logic [DW-1:0] hc;
    held = out_taps; hc = out_cascade;
    out_ready = 1'b0; in_valid = 1'b1; in_data = xh[n]; in_alt = ah[n];
    #1;
    chk("R10", 12'(in_ready), 12'd0);
    repeat (2) @(negedge clk);
    chk("R10", 12'(out_valid), 12'd1);
    chk("R10", out_cascade, hc);
    for (int k = 0; k <= NBUF; k++) chk("R10", out_taps[k], held[k]);
    out_ready = 1'b1;
    beat();
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_data = '0; in_alt = '0;
    cfg_len = '0; cfg_recirc = 0; cfg_pload = 0; cfg_field = 0; cfg_field_buf = 0; cfg_cascade = 0;

    // R1 shortest line
    do_reset(0, 0, 0, 0, 0, 0, 1, "R1");
    repeat (60) beat();
    // R1 length 5 with idle cycles and a stall (R10)
    do_reset(1, 0, 0, 0, 0, 0, 2, "R1");
    for (int i = 0; i < 70; i++) begin beat(); if (i % 3 == 2) gap(); end
    stall();
    repeat (10) beat();
    // R1 middle length; R7 says cfg_field_buf alone changes nothing
    do_reset(100, 0, 0, 0, 1, 0, 3, "R7");
    repeat (800) beat();
    // R1 longest line, whole chain
    do_reset(3072, 0, 0, 0, 0, 0, 4, "R1");
    repeat (7 * 3076 + 12) beat();
    // R2 out-of-range code saturates
    do_reset(4000, 0, 0, 0, 0, 0, 5, "R2");
    repeat (3076 + 12) beat();
    // R6 trimmed first stage
    do_reset(10, 0, 0, 0, 0, 1, 6, "R6");
    repeat (150) beat();
    // R5 preload, also with recirculate requested
    do_reset(6, 0, 1, 0, 0, 0, 7, "R5");
    repeat (40) beat();
    do_reset(6, 1, 1, 0, 0, 1, 8, "R5");
    repeat (40) beat();
    // R4 recirculate after filling, trimmed head
    do_reset(3, 0, 0, 0, 0, 1, 9, "R1");
    repeat (60) beat();
    cfg_recirc = 1'b1; rcm = n; tag = "R4";
    repeat (80) beat();
    // R7 / R8 field input
    do_reset(2, 0, 0, 1, 0, 0, 10, "R1");
    repeat (60) beat();
    do_reset(2, 0, 0, 1, 1, 0, 11, "R1");
    repeat (60) beat();
    do_reset(2, 0, 1, 1, 1, 0, 12, "R5");
    repeat (30) beat();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule